// File: doc/BRIEF.md
# Set-Associative Tag Permission Directory

This block is the tag side of a set-associative cache. Every way of every set stores a line-address tag and a two-bit access permission. A cache controller sends it one command per cycle. The block answers in the same cycle from its registered arrays. It reports whether the line is present or the access is granted, which way was involved, the stored permission, whether the set can take the line, and the line address that the replacement policy would evict. Any change to the tags, the permissions or the replacement state takes effect on the next rising clock edge.

Commands arrive already line-aligned. The low `SET_BITS` bits of the line address select the set, and the remaining upper bits form the tag. Data storage and coherence decisions belong to other blocks. The controller uses the permission field to carry its protocol state. A line that has just been allocated holds an intermediate state until the protocol grants it rights. A build-time parameter picks either true least-recently-used replacement or tree pseudo-LRU replacement.

Top module: `tag_perm_dir`

## Requirements
- R1: After reset, every way of every set holds tag 0 with permission NotPresent. Any lookup then reports a miss with permission 0, and the availability output is 1.
- R2: Permission codes are 0 NotPresent, 1 Invalid, 2 Read-only, 3 Read-write. A way matches only when its tag equals `cmd_addr[ADDR_W-1:SET_BITS]` and its permission is not 0. `rsp_perm` shows the permission of the matching way, or 0 when no way matches. For command 2 (present), `rsp_hit` equals the match.
- R3: Command 0 (access) sets `rsp_hit` only in two cases. The first is a matching way at permission 3. The second is a matching way at permission 2 when `cmd_req` is 0 (load) or 1 (fetch). A store (`cmd_req`=2) to a Read-only line is refused, and every request to an Invalid line is refused.
- R4: Commands 0 and 1 mark the matching way most recently used whenever a tag matches, even if the access is refused.
- R5: Command 1 (test) sets `rsp_hit` whenever a way matches, whatever the request type.
- R6: `rsp_avail` is 1 when some way in the addressed set has an equal tag, whatever its permission, or when some way in that set is NotPresent.
- R7: Command 4 (allocate) writes the tag into the lowest-numbered NotPresent way, sets that way to Invalid and marks it most recently used. `rsp_way` shows that way. If the tag is already present, or if the set has no NotPresent way, `rsp_err` is raised and nothing changes.
- R8: Command 5 (free) sets the matching way to NotPresent. Command 7 (set permission) writes `cmd_perm` into the matching way. When no way matches, either command raises `rsp_err` and changes nothing.
- R9: Command 6 (probe) returns in `rsp_way` the way chosen by the replacement policy, and in `rsp_victim` that way's stored line address. `rsp_err` is raised if the set still has a NotPresent way. `rsp_victim` always shows the policy's candidate for the addressed set.
- R10: With `POLICY`=0, the candidate is the least recently marked way. Just after reset the ways count as marked in the order highest index first, so way `WAYS-1` is the first candidate.
- R11: With `POLICY`=1, each set keeps a binary tree of `WAYS-1` bits, all 0 after reset. Marking a way sets every node on its path to point away from it. The candidate is found by walking from the root, where a 0 bit selects the lower half and a 1 bit the upper half.
- R12: With `cmd_valid` low, `rsp_hit` and `rsp_err` are 0 and the state does not change. Sets are independent: equal tags in different sets do not interact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | 0 access, 1 test, 2 present, 3 avail, 4 allocate, 5 free, 6 probe, 7 set permission |
| cmd_addr | input | ADDR_W | Line address: low SET_BITS bits are the set, the rest are the tag |
| cmd_req | input | 2 | Request type: 0 load, 1 fetch, 2 store |
| cmd_perm | input | 2 | New permission for command 7 |
| rsp_hit | output | 1 | Grant (access) or match (other commands) |
| rsp_way | output | WAY_W | Allocated way (4), victim way (6), otherwise the matching way or 0 |
| rsp_perm | output | 2 | Permission of the matching way, 0 on a miss |
| rsp_avail | output | 1 | The set can take this line |
| rsp_victim | output | ADDR_W | Line address held by the replacement candidate |
| rsp_err | output | 1 | Illegal command for the current state |

## Verification
Tags and permissions show up one cycle after any write: the very next lookup or availability query on that set returns a wrong hit, way or permission. Replacement state is less visible. A wrong age counter or a wrong tree bit changes only `rsp_victim` and the probe way, so an error there can hide until the set is full and probed, or until the bad value is compared in a later cycle. The bench therefore compares every output on every cycle against a model that keeps timestamps and a separate tree. It runs one instance of each policy, so that a refused access, a fresh allocation or a touch on the wrong way shows up as a changed victim in the cycle after it happens.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

    typedef enum logic [1:0] {
        PERM_ABSENT = 2'd0,
        PERM_INVAL  = 2'd1,
        PERM_RDONLY = 2'd2,
        PERM_RDWR   = 2'd3
    } perm_e;

    typedef enum logic [2:0] {
        OP_ACCESS  = 3'd0,
        OP_TEST    = 3'd1,
        OP_PRESENT = 3'd2,
        OP_AVAIL   = 3'd3,
        OP_ALLOC   = 3'd4,
        OP_FREE    = 3'd5,
        OP_PROBE   = 3'd6,
        OP_SETPERM = 3'd7
    } op_e;

    localparam logic [1:0] REQ_LOAD  = 2'd0;
    localparam logic [1:0] REQ_FETCH = 2'd1;
    localparam logic [1:0] REQ_STORE = 2'd2;

    localparam int POLICY_LRU  = 0;
    localparam int POLICY_PLRU = 1;

endpackage

// File: rtl/tpd_set_match.sv
module tpd_set_match
    import tpd_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0][1:0]       set_perms,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       match,
    output logic [WAY_W-1:0]           match_way,
    output logic [1:0]                 match_perm,
    output logic                       any_free,
    output logic [WAY_W-1:0]           free_way,
    output logic                       tag_seen
);

    always_comb begin
        match      = 1'b0;
        match_way  = '0;
        match_perm = PERM_ABSENT;
        any_free   = 1'b0;
        free_way   = '0;
        tag_seen   = 1'b0;
        // walk downward so the lowest qualifying way wins
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (set_tags[w] == req_tag) begin
                tag_seen = 1'b1;
                if (set_perms[w] != PERM_ABSENT) begin
                    match      = 1'b1;
                    match_way  = WAY_W'(w);
                    match_perm = set_perms[w];
                end
            end
            if (set_perms[w] == PERM_ABSENT) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/tpd_repl.sv
module tpd_repl
    import tpd_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int WAYS   = 4,
    parameter int POLICY = POLICY_LRU,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] victim_set,
    output logic [WAY_W-1:0] victim_way
);

    generate
        if (POLICY == POLICY_LRU) begin : g_lru
            logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_d, age_q;
            logic [SETS-1:0][WAYS-1:0]            oldest;

            always_comb begin
                age_d      = age_q;
                victim_way = '0;
                if (touch_en) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                            age_d[touch_set][w] = age_q[touch_set][w] + 1'b1;
                    end
                    age_d[touch_set][touch_way] = '0;
                end
                for (int w = 0; w < WAYS; w++) begin
                    if (age_q[victim_set][w] == WAY_W'(WAYS - 1))
                        victim_way = WAY_W'(w);
                end
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        oldest[s][w] = (age_q[s][w] == WAY_W'(WAYS - 1));
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++)
                        for (int w = 0; w < WAYS; w++)
                            age_q[s][w] <= WAY_W'(w);
                end else begin
                    age_q <= age_d;
                end
            end

            for (genvar s = 0; s < SETS; s++) begin : g_chk
                assert_lru_single_oldest_R10: assert property (
                    @(posedge clk) disable iff (!rst_n)
                    $countones(oldest[s]) == 1
                );
            end
        end else begin : g_plru
            logic [SETS-1:0][WAYS-2:0] tree_d, tree_q;

            always_comb begin
                int node;
                logic dir;
                tree_d     = tree_q;
                victim_way = '0;
                if (touch_en) begin
                    node = 1;
                    for (int l = 0; l < WAY_W; l++) begin
                        dir = touch_way[WAY_W-1-l];
                        tree_d[touch_set][node-1] = ~dir;
                        node = 2 * node + int'(dir);
                    end
                end
                node = 1;
                for (int l = 0; l < WAY_W; l++) begin
                    dir = tree_q[victim_set][node-1];
                    victim_way[WAY_W-1-l] = dir;
                    node = 2 * node + int'(dir);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tree_q <= '0;
                else        tree_q <= tree_d;
            end
        end
    endgenerate

    // a way just marked recent is never the next candidate of its set
    assert_touched_not_victim_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        touch_en |=> ($past(touch_set) != victim_set) || (victim_way != $past(touch_way))
    );

endmodule

// File: rtl/tag_perm_dir.sv
module tag_perm_dir
    import tpd_pkg::*;
#(
    parameter int SET_BITS = 2,
    parameter int WAYS     = 4,
    parameter int ADDR_W   = 12,
    parameter int POLICY   = POLICY_LRU,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_req,
    input  logic [1:0]        cmd_perm,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [1:0]        rsp_perm,
    output logic              rsp_avail,
    output logic [ADDR_W-1:0] rsp_victim,
    output logic              rsp_err
);

    localparam int SETS  = 1 << SET_BITS;
    localparam int SET_W = (SETS > 1) ? SET_BITS : 1;
    localparam int TAG_W = ADDR_W - SET_BITS;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0][1:0]       perm;
    } dir_t;

    dir_t st_d, st_q;

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] req_tag;
    op_e              op;

    logic             m_hit, any_free, tag_seen;
    logic [WAY_W-1:0] m_way, f_way, v_way;
    logic [1:0]       m_perm;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;

    assign set_idx = SET_W'(cmd_addr[SET_BITS-1:0]);
    assign req_tag = cmd_addr[ADDR_W-1:SET_BITS];
    assign op      = op_e'(cmd_op);

    tpd_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .set_tags  (st_q.tag[set_idx]),
        .set_perms (st_q.perm[set_idx]),
        .req_tag   (req_tag),
        .match     (m_hit),
        .match_way (m_way),
        .match_perm(m_perm),
        .any_free  (any_free),
        .free_way  (f_way),
        .tag_seen  (tag_seen)
    );

    tpd_repl #(.SETS(SETS), .WAYS(WAYS), .POLICY(POLICY)) u_repl (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_set (set_idx),
        .touch_way (touch_way),
        .victim_set(set_idx),
        .victim_way(v_way)
    );

    always_comb begin
        st_d      = st_q;
        touch_en  = 1'b0;
        touch_way = m_way;
        rsp_hit   = 1'b0;
        rsp_err   = 1'b0;
        case (op)
            OP_ALLOC: rsp_way = f_way;
            OP_PROBE: rsp_way = v_way;
            default:  rsp_way = m_way;
        endcase
        if (cmd_valid) begin
            case (op)
                OP_ACCESS: begin
                    rsp_hit  = m_hit && ((m_perm == PERM_RDWR) ||
                               ((m_perm == PERM_RDONLY) &&
                                (cmd_req == REQ_LOAD || cmd_req == REQ_FETCH)));
                    touch_en = m_hit;
                end
                OP_TEST: begin
                    rsp_hit  = m_hit;
                    touch_en = m_hit;
                end
                OP_ALLOC: begin
                    rsp_hit = m_hit;
                    if (m_hit || !any_free) begin
                        rsp_err = 1'b1;
                    end else begin
                        st_d.tag[set_idx][f_way]  = req_tag;
                        st_d.perm[set_idx][f_way] = PERM_INVAL;
                        touch_en  = 1'b1;
                        touch_way = f_way;
                    end
                end
                OP_FREE: begin
                    rsp_hit = m_hit;
                    if (!m_hit) rsp_err = 1'b1;
                    else        st_d.perm[set_idx][m_way] = PERM_ABSENT;
                end
                OP_SETPERM: begin
                    rsp_hit = m_hit;
                    if (!m_hit) rsp_err = 1'b1;
                    else        st_d.perm[set_idx][m_way] = cmd_perm;
                end
                OP_PROBE: begin
                    rsp_hit = m_hit;
                    rsp_err = any_free;
                end
                default: rsp_hit = m_hit;
            endcase
        end
    end

    assign rsp_perm   = m_perm;
    assign rsp_avail  = tag_seen || any_free;
    assign rsp_victim = {st_q.tag[set_idx][v_way], cmd_addr[SET_BITS-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_grant_needs_rights_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_ACCESS && rsp_hit) |->
            (rsp_perm == PERM_RDWR) || (rsp_perm == PERM_RDONLY && cmd_req != REQ_STORE)
    );

    assert_alloc_installs_invalid_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_ALLOC && !rsp_err) |=>
            (st_q.perm[$past(set_idx)][$past(rsp_way)] == PERM_INVAL)
    );

    assert_miss_keeps_state_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == OP_FREE || op == OP_SETPERM) && rsp_err) |=> $stable(st_q)
    );

    assert_probe_set_full_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_PROBE && !rsp_err) |->
            (st_q.perm[set_idx][rsp_way] != PERM_ABSENT)
    );

    assert_idle_no_change_R12: assert property (
        @(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(st_q)
    );

endmodule

// File: tb/tb_tag_perm_dir.sv
`timescale 1ns/1ps
module tb_tag_perm_dir;

    localparam int SB     = 2;
    localparam int SETS   = 1 << SB;
    localparam int WAYS   = 4;
    localparam int LW     = 2;
    localparam int ADDR_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [1:0] cmd_req = '0;
    logic [1:0] cmd_perm = '0;

    logic hit_a, hit_b, av_a, av_b, err_a, err_b;
    logic [LW-1:0] way_a, way_b;
    logic [1:0] perm_a, perm_b;
    logic [ADDR_W-1:0] vic_a, vic_b;

    always #2 clk = ~clk;

    tag_perm_dir #(.SET_BITS(SB), .WAYS(WAYS), .ADDR_W(ADDR_W), .POLICY(0)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_req(cmd_req), .cmd_perm(cmd_perm),
        .rsp_hit(hit_a), .rsp_way(way_a), .rsp_perm(perm_a), .rsp_avail(av_a),
        .rsp_victim(vic_a), .rsp_err(err_a));

    tag_perm_dir #(.SET_BITS(SB), .WAYS(WAYS), .ADDR_W(ADDR_W), .POLICY(1)) dut_plru (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_req(cmd_req), .cmd_perm(cmd_perm),
        .rsp_hit(hit_b), .rsp_way(way_b), .rsp_perm(perm_b), .rsp_avail(av_b),
        .rsp_victim(vic_b), .rsp_err(err_b));

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int  mtag  [SETS][WAYS];
    int  mperm [SETS][WAYS];
    int  stamp [SETS][WAYS];
    bit  ptree [SETS][WAYS];
    int  now = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic touch(int s, int w);
        int n;
        now++;
        stamp[s][w] = now;
        n = 1;
        for (int l = 0; l < LW; l++) begin
            int d;
            d = (w >> (LW - 1 - l)) & 1;
            ptree[s][n] = (d == 0);
            n = 2 * n + d;
        end
    endtask

    task automatic do_op(bit v, int op, int addr, int rq, int np);
        int s, tg, mw, mp, fw, lw, pw, ew;
        bit mt, fr, seen, eh, ee;
        string hr, er, wr;
        @(negedge clk);
        cmd_valid = v; cmd_op = 3'(op); cmd_addr = ADDR_W'(addr);
        cmd_req = 2'(rq); cmd_perm = 2'(np);
        #1;
        s = addr % SETS; tg = addr / SETS;
        mt = 0; mw = 0; mp = 0; fr = 0; fw = 0; seen = 0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (mtag[s][w] == tg) begin
                seen = 1;
                if (mperm[s][w] != 0) begin mt = 1; mw = w; mp = mperm[s][w]; end
            end
            if (mperm[s][w] == 0) begin fr = 1; fw = w; end
        end
        lw = 0;
        for (int w = 1; w < WAYS; w++) if (stamp[s][w] < stamp[s][lw]) lw = w;
        begin
            int n;
            n = 1; pw = 0;
            for (int l = 0; l < LW; l++) begin
                pw = pw * 2 + int'(ptree[s][n]);
                n = 2 * n + int'(ptree[s][n]);
            end
        end
        eh = 0; ee = 0; ew = mw; hr = "R2"; er = "R12"; wr = "R2";
        case (op)
            0: begin hr = "R3"; eh = mt && (mp == 3 || (mp == 2 && (rq == 0 || rq == 1))); end
            1: begin hr = "R5"; eh = mt; end
            4: begin eh = mt; ee = mt || !fr; er = "R7"; ew = fw; wr = "R7"; end
            5, 7: begin eh = mt; ee = !mt; er = "R8"; end
            6: begin eh = mt; ee = fr; er = "R9"; wr = "R9"; end
            default: eh = mt;
        endcase
        if (!v) begin eh = 0; ee = 0; hr = "R12"; er = "R12"; end
        chk(hr, "hit", int'(hit_a), int'(eh));
        chk(hr, "hit_plru", int'(hit_b), int'(eh));
        chk(er, "err", int'(err_a), int'(ee));
        chk(er, "err_plru", int'(err_b), int'(ee));
        chk("R2", "perm", int'(perm_a), mt ? mp : 0);
        chk("R2", "perm_plru", int'(perm_b), mt ? mp : 0);
        chk("R6", "avail", int'(av_a), int'(seen || fr));
        chk("R6", "avail_plru", int'(av_b), int'(seen || fr));
        chk(op == 6 ? "R10" : wr, "way", int'(way_a), op == 6 ? lw : ew);
        chk(op == 6 ? "R11" : wr, "way_plru", int'(way_b), op == 6 ? pw : ew);
        chk("R10", "victim", int'(vic_a), mtag[s][lw] * SETS + s);
        chk("R11", "victim_plru", int'(vic_b), mtag[s][pw] * SETS + s);
        if (v) begin
            case (op)
                0, 1: if (mt) touch(s, mw);
                4: if (!ee) begin mtag[s][fw] = tg; mperm[s][fw] = 1; touch(s, fw); end
                5: if (mt) mperm[s][mw] = 0;
                7: if (mt) mperm[s][mw] = np;
                default: ;
            endcase
        end
    endtask

    function automatic int la(int tg, int s);
        return tg * SETS + s;
    endfunction

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                mtag[s][w] = 0; mperm[s][w] = 0; stamp[s][w] = -w; ptree[s][w] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, every set empty and available
        for (int s = 0; s < SETS; s++) do_op(1, 2, la(0, s), 0, 0);
        for (int s = 0; s < SETS; s++) do_op(1, 3, la(5, s), 0, 0);
        // R7: fill set 1 in order, then an overflow and a duplicate
        for (int t = 1; t <= WAYS; t++) do_op(1, 4, la(t, 1), 0, 0);
        do_op(1, 4, la(9, 1), 0, 0);
        do_op(1, 4, la(2, 1), 0, 0);
        // R3 R4: refused access to Invalid still touches
        do_op(1, 0, la(1, 1), 0, 0);
        do_op(1, 6, la(9, 1), 0, 0);
        // R3: read-only line, load/fetch granted, store refused
        do_op(1, 7, la(3, 1), 0, 2);
        do_op(1, 0, la(3, 1), 0, 0);
        do_op(1, 0, la(3, 1), 1, 0);
        do_op(1, 0, la(3, 1), 2, 0);
        do_op(1, 7, la(4, 1), 0, 3);
        do_op(1, 0, la(4, 1), 2, 0);
        // R5: test hits on Invalid for store
        do_op(1, 1, la(2, 1), 2, 0);
        do_op(1, 6, la(0, 1), 0, 0);
        // R8: free then miss on free and setperm
        do_op(1, 5, la(2, 1), 0, 0);
        do_op(1, 5, la(2, 1), 0, 0);
        do_op(1, 7, la(2, 1), 0, 3);
        // R6: equal tag with NotPresent way still available; R9 probe error
        do_op(1, 3, la(2, 1), 0, 0);
        do_op(1, 6, la(2, 1), 0, 0);
        // R7: refill takes the freed (lowest) way
        do_op(1, 4, la(7, 1), 0, 0);
        // R12: same tag in another set is independent; idle changes nothing
        do_op(1, 2, la(3, 2), 0, 0);
        do_op(0, 4, la(3, 2), 0, 0);
        do_op(1, 2, la(3, 2), 0, 0);
        // mixed random traffic over a small tag space
        for (int i = 0; i < 3000; i++) begin
            int op, r;
            r = $urandom_range(0, 99);
            if (r < 20) op = 4; else if (r < 40) op = 0; else if (r < 50) op = 1;
            else if (r < 58) op = 5; else if (r < 70) op = 7; else if (r < 80) op = 6;
            else op = $urandom_range(2, 3);
            do_op($urandom_range(0, 15) != 0, op, la($urandom_range(0, 6), $urandom_range(0, SETS - 1)),
                  $urandom_range(0, 2), $urandom_range(0, 3));
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule